// File: doc/BRIEF.md
# Banked Memory Address Translator

This block widens the 16-bit logical address of a small processor into a 20-bit physical RAM address. It appends a 4-bit bank number above the logical address. A programmable boundary splits the logical space into two parts. One part is common and is never banked. The other part is banked and carries the selected bank number. A mode bit chooses which side of the boundary holds the common part, so the common window can sit at the bottom or at the top of the logical space.

Software chooses a bank by writing to a fixed I/O port. A write with a bank number that is out of range is refused, and the block reports it on a one-cycle flag. The boundary and the mode bit are loaded through a separate configuration write interface. The physical address is combinational from the logical address and the registered state. When the banked-mode enable is low, the logical address passes straight through with zero upper bits.

All pins are plain control or data pins. There is no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `bank_xlat_top`

## Requirements
- R1: After a synchronous reset the bank register is 0, the boundary is 0xC000 and the common-low mode is off. With banked mode enabled, every logical address therefore maps to itself with upper bits zero.
- R2: An I/O write (`io_wr` high) to port 0x40 with data below 16 loads data[3:0] into the bank register. The new bank is visible on `phys_addr` from the cycle after the strobe.
- R3: An I/O write to port 0x40 with data of 16 or more leaves the bank register unchanged. It also drives `bank_reject` high for exactly the one cycle after the strobe.
- R4: I/O writes to any port other than 0x40 leave the bank register unchanged and do not raise `bank_reject`.
- R5: With banked mode on and common-low off, a logical address below the boundary is banked. An address at or above the boundary is common.
- R6: With banked mode on and common-low on, a logical address at or above the boundary is banked. An address below the boundary is common.
- R7: When `banked_en` is low, `phys_addr` equals the logical address with bits 19:16 zero, whatever bank is selected.
- R8: A `cfg_wr` pulse loads `cfg_boundary` and `cfg_common_low`, and they take effect from the next cycle.
- R9: For a banked access, `phys_addr[19:16]` holds the bank number. For a common access those bits are zero. In both cases `phys_addr[15:0]` equals `log_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_boundary | input | 16 | New region boundary |
| cfg_common_low | input | 1 | New mode: 1 places the common region below the boundary |
| banked_en | input | 1 | Enables bank translation |
| log_addr | input | 16 | Logical address from the processor |
| phys_addr | output | 20 | Physical RAM address |
| bank_reject | output | 1 | One-cycle pulse after a refused bank write |

## Verification
A wrong bank register shows in `phys_addr[19:16]` on the first banked access after the faulty write. The bench probes such an access one cycle after every write. A wrong boundary or mode shows only at addresses near the boundary. For that reason the vectors probe the boundary itself and the address just below it in both modes. A refused write that still altered the bank is caught by reading a banked address right after the `bank_reject` pulse.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  typedef enum logic {
    MODE_COMMON_HIGH = 1'b0,
    MODE_COMMON_LOW  = 1'b1
  } common_mode_e;
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
  parameter int IO_AW = 8,
  parameter int IO_DW = 8,
  parameter int BANK_W = 4,
  parameter logic [IO_AW-1:0] SEL_PORT = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [IO_DW-1:0]  io_data,
  output logic [BANK_W-1:0] bank_q,
  output logic              reject_q
);
  localparam int NUM_BANKS = 1 << BANK_W;

  logic hit;
  logic in_range;

  assign hit      = io_wr && (io_addr == SEL_PORT);
  assign in_range = (int'(io_data) < NUM_BANKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q   <= '0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= hit && !in_range;
      if (hit && in_range) bank_q <= io_data[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/xlat_cfg_reg.sv
module xlat_cfg_reg
  import bank_xlat_pkg::*;
#(
  parameter int LOG_W = 16,
  parameter logic [LOG_W-1:0] RESET_BOUNDARY = 16'hC000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [LOG_W-1:0] cfg_boundary,
  input  logic             cfg_common_low,
  output logic [LOG_W-1:0] boundary_q,
  output common_mode_e     mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      boundary_q <= RESET_BOUNDARY;
      mode_q     <= MODE_COMMON_HIGH;
    end else if (cfg_wr) begin
      boundary_q <= cfg_boundary;
      mode_q     <= common_mode_e'(cfg_common_low);
    end
  end
endmodule

// File: rtl/xlat_addr_form.sv
module xlat_addr_form
  import bank_xlat_pkg::*;
#(
  parameter int LOG_W = 16,
  parameter int BANK_W = 4
) (
  input  logic                    banked_en,
  input  logic [LOG_W-1:0]        log_addr,
  input  logic [LOG_W-1:0]        boundary,
  input  common_mode_e            mode,
  input  logic [BANK_W-1:0]       bank,
  output logic [LOG_W+BANK_W-1:0] phys_addr
);
  logic above;
  logic is_banked;

  assign above = (log_addr >= boundary);

  always_comb begin
    unique case (mode)
      MODE_COMMON_LOW: is_banked = above;
      default:         is_banked = !above;
    endcase
  end

  assign phys_addr = {(banked_en && is_banked) ? bank : {BANK_W{1'b0}}, log_addr};
endmodule

// File: rtl/bank_xlat_top.sv
module bank_xlat_top
  import bank_xlat_pkg::*;
#(
  parameter int LOG_W = 16,
  parameter int BANK_W = 4,
  parameter int IO_AW = 8,
  parameter int IO_DW = 8,
  parameter logic [IO_AW-1:0] SEL_PORT = 8'h40,
  parameter logic [LOG_W-1:0] RESET_BOUNDARY = 16'hC000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    io_wr,
  input  logic [IO_AW-1:0]        io_addr,
  input  logic [IO_DW-1:0]        io_data,
  input  logic                    cfg_wr,
  input  logic [LOG_W-1:0]        cfg_boundary,
  input  logic                    cfg_common_low,
  input  logic                    banked_en,
  input  logic [LOG_W-1:0]        log_addr,
  output logic [LOG_W+BANK_W-1:0] phys_addr,
  output logic                    bank_reject
);
  logic [BANK_W-1:0] bank_q;
  logic [LOG_W-1:0]  boundary_q;
  common_mode_e      mode_q;

  bank_sel_reg #(
    .IO_AW(IO_AW), .IO_DW(IO_DW), .BANK_W(BANK_W), .SEL_PORT(SEL_PORT)
  ) u_bank (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .bank_q(bank_q), .reject_q(bank_reject)
  );

  xlat_cfg_reg #(
    .LOG_W(LOG_W), .RESET_BOUNDARY(RESET_BOUNDARY)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_boundary(cfg_boundary),
    .cfg_common_low(cfg_common_low), .boundary_q(boundary_q), .mode_q(mode_q)
  );

  xlat_addr_form #(
    .LOG_W(LOG_W), .BANK_W(BANK_W)
  ) u_form (
    .banked_en(banked_en), .log_addr(log_addr), .boundary(boundary_q),
    .mode(mode_q), .bank(bank_q), .phys_addr(phys_addr)
  );
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk #(
  parameter int LOG_W = 16,
  parameter int BANK_W = 4,
  parameter int IO_AW = 8,
  parameter int IO_DW = 8,
  parameter logic [IO_AW-1:0] SEL_PORT = 8'h40
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    io_wr,
  input logic [IO_AW-1:0]        io_addr,
  input logic [IO_DW-1:0]        io_data,
  input logic                    cfg_wr,
  input logic [LOG_W-1:0]        cfg_boundary,
  input logic                    banked_en,
  input logic [LOG_W-1:0]        log_addr,
  input logic [LOG_W+BANK_W-1:0] phys_addr,
  input logic                    bank_reject,
  input logic [BANK_W-1:0]       bank_q,
  input logic [LOG_W-1:0]        boundary_q
);
  localparam int NUM_BANKS = 1 << BANK_W;

  a_r2_bank_load: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == SEL_PORT && int'(io_data) < NUM_BANKS)
      |=> bank_q == $past(io_data[BANK_W-1:0]));

  a_r3_reject: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == SEL_PORT && int'(io_data) >= NUM_BANKS)
      |=> bank_reject && $stable(bank_q));

  a_r4_other_port: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr != SEL_PORT) |=> !bank_reject && $stable(bank_q));

  a_r7_passthru: assert property (@(posedge clk) disable iff (rst)
    !banked_en |-> phys_addr[LOG_W+BANK_W-1:LOG_W] == '0);

  a_r9_low_bits: assert property (@(posedge clk) disable iff (rst)
    phys_addr[LOG_W-1:0] == log_addr);

  a_r8_cfg_load: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> boundary_q == $past(cfg_boundary));
endmodule

bind bank_xlat_top bank_xlat_chk #(
  .LOG_W(LOG_W), .BANK_W(BANK_W), .IO_AW(IO_AW), .IO_DW(IO_DW), .SEL_PORT(SEL_PORT)
) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
  .cfg_wr(cfg_wr), .cfg_boundary(cfg_boundary), .banked_en(banked_en),
  .log_addr(log_addr), .phys_addr(phys_addr), .bank_reject(bank_reject),
  .bank_q(bank_q), .boundary_q(boundary_q)
);

// File: tb/sim_bank_xlat_top.sv
module sim_bank_xlat_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        io_wr;
  logic [7:0]  io_addr;
  logic [7:0]  io_data;
  logic        cfg_wr;
  logic [15:0] cfg_boundary;
  logic        cfg_common_low;
  logic        banked_en;
  logic [15:0] log_addr;
  logic [19:0] phys_addr;
  logic        bank_reject;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bank_xlat_top u0 (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .cfg_wr(cfg_wr), .cfg_boundary(cfg_boundary), .cfg_common_low(cfg_common_low),
    .banked_en(banked_en), .log_addr(log_addr), .phys_addr(phys_addr),
    .bank_reject(bank_reject)
  );

  // vector: {bank[3:0], common_low, boundary[15:0], en, addr[15:0], expected[19:0]}
  localparam int NV = 10;
  localparam logic [57:0] VEC [NV] = '{
    {4'h5, 1'b0, 16'hC000, 1'b1, 16'h1234, 20'h51234},  // R5 banked below
    {4'h5, 1'b0, 16'hC000, 1'b1, 16'hBFFF, 20'h5BFFF},  // R5 just below boundary
    {4'h5, 1'b0, 16'hC000, 1'b1, 16'hC000, 20'h0C000},  // R5 at boundary common
    {4'hF, 1'b0, 16'hC000, 1'b1, 16'hFFFF, 20'h0FFFF},  // R5 top common
    {4'h9, 1'b1, 16'h4000, 1'b1, 16'h3FFF, 20'h03FFF},  // R6 below common
    {4'h9, 1'b1, 16'h4000, 1'b1, 16'h4000, 20'h94000},  // R6 at boundary banked
    {4'hF, 1'b1, 16'h4000, 1'b1, 16'hFFFF, 20'hFFFFF},  // R6 R9 top banked
    {4'hA, 1'b1, 16'h4000, 1'b1, 16'h0000, 20'h00000},  // R6 zero common
    {4'hA, 1'b0, 16'h8000, 1'b0, 16'h1000, 20'h01000},  // R7 pass-through
    {4'hA, 1'b1, 16'h8000, 1'b0, 16'h9000, 20'h09000}   // R7 pass-through
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [15:0] b, input logic cl);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_boundary = b; cfg_common_low = cl;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; io_wr = 1'b0; io_addr = '0; io_data = '0;
    cfg_wr = 1'b0; cfg_boundary = '0; cfg_common_low = 1'b0;
    banked_en = 1'b1; log_addr = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, bank 0, boundary C000, mode common-high
    log_addr = 16'h2345; #1 check("R1", phys_addr, 20'h02345);
    log_addr = 16'hC123; #1 check("R1", phys_addr, 20'h0C123);
    check("R1", {19'd0, bank_reject}, 20'd0);

    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][52:37], VEC[i][53]);
      io_write(8'h40, {4'h0, VEC[i][57:54]});
      banked_en = VEC[i][36];
      log_addr  = VEC[i][35:20];
      #1 check("R5/R6/R7/R9 vector", phys_addr, VEC[i][19:0]);
    end

    // R2: a new bank is seen in the cycle after the strobe
    cfg_write(16'hC000, 1'b0);
    banked_en = 1'b1; log_addr = 16'h0100;
    io_write(8'h40, 8'h03);
    #1 check("R2", phys_addr, 20'h30100);
    io_write(8'h40, 8'h0F);
    #1 check("R2 max bank", phys_addr, 20'hF0100);

    // R3: refused values 16 and FF keep bank F and pulse the flag once
    @(negedge clk);
    io_wr = 1'b1; io_addr = 8'h40; io_data = 8'h10;
    @(negedge clk);
    io_wr = 1'b0;
    check("R3 flag", {19'd0, bank_reject}, 20'd1);
    check("R3 bank kept", phys_addr, 20'hF0100);
    @(negedge clk);
    check("R3 flag one cycle", {19'd0, bank_reject}, 20'd0);
    io_write(8'h40, 8'hFF);
    check("R3 bank kept FF", phys_addr, 20'hF0100);

    // R4: other ports ignored
    @(negedge clk);
    io_wr = 1'b1; io_addr = 8'h41; io_data = 8'h02;
    @(negedge clk);
    io_wr = 1'b0;
    check("R4 no flag", {19'd0, bank_reject}, 20'd0);
    check("R4 bank kept", phys_addr, 20'hF0100);
    io_write(8'hC0, 8'h20);
    check("R4 no flag C0", {19'd0, bank_reject}, 20'd0);
    check("R4 bank kept C0", phys_addr, 20'hF0100);

    // R8: config takes effect one cycle after cfg_wr
    log_addr = 16'h9000;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_boundary = 16'h8000; cfg_common_low = 1'b0;
    #1 check("R8 before", phys_addr, 20'hF9000);
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R8 after", phys_addr, 20'h09000);

    // R1: reset returns to the default state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    log_addr = 16'hBFFF; #1 check("R1 re-reset", phys_addr, 20'h0BFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule